// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised set of peripheral lines and from eight software-settable request bits. Each source carries a programmable 4-bit priority. Out of all pending sources it picks one and presents a single request to the processor, with a 9-bit vector that names the winning source. A source only wins if its priority is strictly above the current priority. The block therefore preempts running work only when the new request is more urgent.

Taking an interrupt saves the priority that was running onto an internal last-in-first-out stack. The current priority then becomes that of the accepted source. An end-of-interrupt write restores the saved level. Software may also overwrite the current priority directly. This raises a ceiling while a shared resource is in use, so that no other task that uses the resource can cut in.

Two acknowledge handshakes are provided, chosen by a mode bit. In hardware mode the processor accepts the presented vector with a strobe pin. In software mode a common handler reads the pending-vector register, and that read is the acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each source has a 4-bit priority register at address 0x100 plus its source number. It reads back what was written and resets to 0. A source at priority 0 never raises the processor request.
- R2: Software sources have source numbers 0 to 7. Peripheral line j has source number 8+j. The vector is the source number. A source wins only if its priority is strictly greater than the current priority. Among equal winners, the lowest source number wins.
- R3: Suppose a peripheral line rises and the register state is unchanged. After the second rising clock edge, irq_out is still low. After the third rising edge, irq_out is high with the vector of that line.
- R4: Hardware mode is bit 0 of address 0x000 set to 1. In this mode, irq_ack sampled high while irq_out is high takes the interrupt. The old current priority is pushed, the current priority becomes the source's priority, and irq_out is low after that same edge.
- R5: Software mode is bit 0 of address 0x000 set to 0. In this mode, a read of address 0x004 returns irq_out in bit 15 and vec_out in bits 8:0. When irq_out is high, that read takes the interrupt as in R4. The irq_ack pin has no effect in software mode.
- R6: A write to address 0x005 is an end-of-interrupt. It pops the last saved priority into the current priority. If the stack is empty, the current priority becomes 0 and a sticky error bit is set. That bit is bit 0 of address 0x006, and any write to 0x006 clears it.
- R7: Address 0x001 holds the current priority in bits 3:0. It can be written and read. Raising it holds off every source at or below the new level.
- R8: A write to address 0x002 sets the software request bits given as ones in wdata[7:0]. A write to 0x003 clears them. Reading 0x002 returns the software request bits.
- R9: If an acknowledge and an end-of-interrupt fall in the same cycle, the pop is applied first. The restored level is pushed again, and the current priority becomes the acknowledged source's priority. The stack depth is therefore unchanged.
- R10: After reset, the current priority is 0, the stack is empty, irq_out is low, software mode is selected, and the error bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | N_PERIPH | Level peripheral requests |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 10 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irq_ack | input | 1 | Acknowledge strobe (hardware mode) |
| irq_out | output | 1 | Interrupt request to processor |
| vec_out | output | 9 | Source number of the request |

## Verification
The acknowledge of the presented source and an end-of-interrupt can fall in the same clock. The bench provokes this by raising irq_ack and writing the end-of-interrupt address on the same edge, during a nested service where one level is already saved. It then judges the result from the ports alone. The current priority must read back as the new source's level. The next end-of-interrupt must restore the level saved before the nesting, and a further one must set the underflow error, which proves the stack depth did not change.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int PRIO_W  = 4;
  localparam int VEC_W   = 9;
  localparam int N_SW    = 8;
  localparam int ADDR_W  = 10;
  localparam int WDATA_W = 8;
  localparam int RDATA_W = 16;

  localparam logic [ADDR_W-1:0] A_MODE   = 10'h000;
  localparam logic [ADDR_W-1:0] A_CUR    = 10'h001;
  localparam logic [ADDR_W-1:0] A_SWSET  = 10'h002;
  localparam logic [ADDR_W-1:0] A_SWCLR  = 10'h003;
  localparam logic [ADDR_W-1:0] A_VEC    = 10'h004;
  localparam logic [ADDR_W-1:0] A_EOI    = 10'h005;
  localparam logic [ADDR_W-1:0] A_ERR    = 10'h006;
  localparam int                PRIO_BASE = 'h100;

  typedef struct packed {
    logic              valid;
    logic [VEC_W-1:0]  vec;
    logic [PRIO_W-1:0] prio;
  } win_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 24
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      cur,
  output win_t                   win
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare keeps the lowest index on ties.
  always_comb begin
    best = cur;
    win  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        best      = prio_flat[i*PRIO_W +: PRIO_W];
        win.valid = 1'b1;
        win.vec   = VEC_W'(i);
        win.prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_prio_lifo.sv
module irq_prio_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] after_pop;
  logic          do_push;

  assign empty     = (cnt_q == '0);
  assign after_pop = (pop && !empty) ? cnt_q - 1'b1 : cnt_q;
  assign full      = (after_pop == CW'(DEPTH));
  assign do_push   = push && !full;
  assign top       = mem[IW'(cnt_q - 1'b1)];
  assign count     = cnt_q;

  // Storage has no reset so it can map to distributed or block RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[IW'(after_pop)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= after_pop + CW'(do_push);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_PERIPH = 16,
  localparam int NSRC    = N_SW + N_PERIPH,
  localparam int DEPTH   = 1 << PRIO_W,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] periph_req,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WDATA_W-1:0]  wdata,
  output logic [RDATA_W-1:0]  rdata,
  input  logic                irq_ack,
  output logic                irq_out,
  output logic [VEC_W-1:0]    vec_out
);
  logic                 mode_q;
  logic [N_SW-1:0]      sw_q;
  logic [PRIO_W-1:0]    prio_q [NSRC];
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic                 err_q;
  logic [N_PERIPH-1:0]  req_q;
  logic [PRIO_W-1:0]    cur_q;
  logic [PRIO_W-1:0]    out_prio_q;
  win_t                 win_c, win_q;
  logic [NSRC-1:0]      pend;

  logic                 ack_evt, eoi_evt, flush;
  logic [PRIO_W-1:0]    base_prio, lifo_top;
  logic                 lifo_empty, lifo_full;
  logic [CW-1:0]        lifo_cnt;
  logic [RDATA_W-1:0]   rd_c;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_flat
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
  endgenerate

  assign pend = {req_q, sw_q};

  assign ack_evt = irq_out &&
                   ((mode_q && irq_ack) || (!mode_q && rd_en && addr == A_VEC));
  assign eoi_evt = wr_en && (addr == A_EOI);
  assign flush   = wr_en || ack_evt;
  assign base_prio = eoi_evt ? (lifo_empty ? '0 : lifo_top) : cur_q;

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .pend      (pend),
    .prio_flat (prio_flat),
    .cur       (cur_q),
    .win       (win_c)
  );

  irq_prio_lifo #(.DEPTH(DEPTH), .W(PRIO_W)) u_lifo (
    .clk   (clk),
    .rst   (rst),
    .push  (ack_evt),
    .pop   (eoi_evt),
    .din   (base_prio),
    .top   (lifo_top),
    .empty (lifo_empty),
    .full  (lifo_full),
    .count (lifo_cnt)
  );

  // Input stage, arbitration stage and output stage; any state change flushes.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= '0;
      win_q      <= '0;
      irq_out    <= 1'b0;
      vec_out    <= '0;
      out_prio_q <= '0;
    end else begin
      req_q      <= periph_req;
      win_q      <= flush ? '0 : win_c;
      irq_out    <= flush ? 1'b0 : win_q.valid;
      vec_out    <= win_q.vec;
      out_prio_q <= win_q.prio;
    end
  end

  // Current priority: acknowledge wins over a direct write.
  always_ff @(posedge clk) begin
    if (rst)                           cur_q <= '0;
    else if (ack_evt)                  cur_q <= out_prio_q;
    else if (wr_en && addr == A_CUR)   cur_q <= wdata[PRIO_W-1:0];
    else                               cur_q <= base_prio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      sw_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_MODE)  mode_q <= wdata[0];
      if (wr_en && addr == A_SWSET) sw_q   <= sw_q | wdata[N_SW-1:0];
      if (wr_en && addr == A_SWCLR) sw_q   <= sw_q & ~wdata[N_SW-1:0];
      if (wr_en && addr == A_ERR)                 err_q <= 1'b0;
      else if ((eoi_evt && lifo_empty) || (ack_evt && lifo_full)) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (rst)                                          prio_q[i] <= '0;
      else if (wr_en && addr == ADDR_W'(PRIO_BASE + i)) prio_q[i] <= wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_c = '0;
    case (addr)
      A_MODE:  rd_c[0]          = mode_q;
      A_CUR:   rd_c[PRIO_W-1:0] = cur_q;
      A_SWSET: rd_c[N_SW-1:0]   = sw_q;
      A_VEC:   rd_c = {irq_out, {(RDATA_W-1-VEC_W){1'b0}}, vec_out};
      A_ERR:   rd_c[0]          = err_q;
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (addr == ADDR_W'(PRIO_BASE + i)) rd_c[PRIO_W-1:0] = prio_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_c;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_out,
  input logic              irq_ack,
  input logic              rd_en,
  input logic              wr_en,
  input logic              ack_evt,
  input logic              eoi_evt,
  input logic              lifo_empty,
  input logic              err_q,
  input logic [PRIO_W-1:0] cur_q,
  input logic [PRIO_W-1:0] out_prio_q,
  input logic [CW-1:0]     lifo_cnt
);
  // R2
  win_above_cur_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (out_prio_q > cur_q));
  // R4
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ack_evt |=> !irq_out);
  // R4
  ack_loads_prio_chk: assert property (@(posedge clk) disable iff (rst)
    ack_evt |=> (cur_q == $past(out_prio_q)));
  // R6
  eoi_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_evt && lifo_empty && !ack_evt) |=> (err_q && cur_q == '0));
  // R5
  idle_cur_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_evt && !wr_en && !rd_en && !irq_ack) |=> $stable(cur_q));
  // R10
  lifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lifo_cnt <= CW'(DEPTH));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_out    (irq_out),
  .irq_ack    (irq_ack),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .ack_evt    (ack_evt),
  .eoi_evt    (eoi_evt),
  .lifo_empty (lifo_empty),
  .err_q      (err_q),
  .cur_q      (cur_q),
  .out_prio_q (out_prio_q),
  .lifo_cnt   (lifo_cnt)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] periph_req = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
  logic [9:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq_out;
  logic [8:0]  vec_out;
  int          n_run = 0, n_fail = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.N_PERIPH(16)) dut (
    .clk(clk), .rst(rst), .periph_req(periph_req), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_ack(irq_ack), .irq_out(irq_out), .vec_out(vec_out)
  );

  // {peripheral mask, current priority, expected irq, expected vector}
  // peripheral line j has priority (j & 7) + 1
  localparam logic [29:0] TBL [10] = '{
    {16'h0000, 4'd0, 1'b0, 9'd0},
    {16'h0001, 4'd0, 1'b1, 9'd8},
    {16'h0101, 4'd0, 1'b1, 9'd8},
    {16'h0100, 4'd0, 1'b1, 9'd16},
    {16'h8080, 4'd0, 1'b1, 9'd15},
    {16'h8080, 4'd8, 1'b0, 9'd0},
    {16'h8080, 4'd7, 1'b1, 9'd15},
    {16'h00F0, 4'd5, 1'b1, 9'd15},
    {16'h4020, 4'd6, 1'b1, 9'd22},
    {16'h0003, 4'd1, 1'b1, 9'd9}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ack_pin();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", int'(irq_out), 0);
    rd(10'h001, rv); chk("R10 cur", int'(rv), 0);
    rd(10'h000, rv); chk("R10 mode", int'(rv), 0);
    rd(10'h006, rv); chk("R10 err", int'(rv), 0);

    for (int j = 0; j < 16; j++) wr(10'(10'h108 + j), 8'((j & 7) + 1));
    rd(10'h10F, rv); chk("R1 prio readback", int'(rv), 8);

    // R2 / R7 table walk
    for (int k = 0; k < 10; k++) begin
      periph_req = TBL[k][29:14];
      wr(10'h001, {4'd0, TBL[k][13:10]});
      settle();
      chk($sformatf("R2 irq entry %0d", k), int'(irq_out), int'(TBL[k][9]));
      if (TBL[k][9]) chk($sformatf("R2 vec entry %0d", k), int'(vec_out), int'(TBL[k][8:0]));
    end
    wr(10'h001, 8'd9); rd(10'h001, rv); chk("R7 cur readback", int'(rv), 9);
    periph_req = 16'h00FF; settle();
    chk("R7 ceiling holds off", int'(irq_out), 0);
    periph_req = '0;
    wr(10'h001, 8'd0);
    settle();

    // R3 latency
    periph_req = 16'h0008;
    @(negedge clk); @(negedge clk);
    chk("R3 low after two edges", int'(irq_out), 0);
    @(negedge clk);
    chk("R3 high after three edges", int'(irq_out), 1);
    chk("R3 vec", int'(vec_out), 11);
    periph_req = '0; settle();

    // R4 / R6 nesting in hardware mode
    wr(10'h000, 8'd1);
    periph_req = 16'h0001; settle();
    chk("R4 irq j0", int'(vec_out), 8);
    ack_pin();
    chk("R4 irq drops", int'(irq_out), 0);
    rd(10'h001, rv); chk("R4 cur after ack", int'(rv), 1);
    periph_req = 16'h0009; settle();
    chk("R4 preempt vec", int'(vec_out), 11);
    ack_pin();
    rd(10'h001, rv); chk("R4 nested cur", int'(rv), 4);
    wr(10'h005, 8'd0); rd(10'h001, rv); chk("R6 pop to 1", int'(rv), 1);
    wr(10'h005, 8'd0); rd(10'h001, rv); chk("R6 pop to 0", int'(rv), 0);
    wr(10'h005, 8'd0); rd(10'h006, rv); chk("R6 underflow err", int'(rv), 1);
    rd(10'h001, rv); chk("R6 cur stays 0", int'(rv), 0);
    wr(10'h006, 8'd0); rd(10'h006, rv); chk("R6 err cleared", int'(rv), 0);

    // R9 acknowledge and end-of-interrupt in one cycle
    periph_req = 16'h0001; settle();
    ack_pin();
    periph_req = 16'h0009; settle();
    chk("R9 pending vec", int'(vec_out), 11);
    irq_ack = 1'b1; wr_en = 1'b1; addr = 10'h005; wdata = 8'd0;
    @(negedge clk);
    irq_ack = 1'b0; wr_en = 1'b0;
    rd(10'h001, rv); chk("R9 cur", int'(rv), 4);
    wr(10'h005, 8'd0); rd(10'h001, rv); chk("R9 restored", int'(rv), 0);
    wr(10'h005, 8'd0); rd(10'h006, rv); chk("R9 depth unchanged", int'(rv), 1);
    wr(10'h006, 8'd0);
    periph_req = '0;

    // R1 / R5 / R8 software sources in software mode
    wr(10'h000, 8'd0);
    wr(10'h002, 8'h20); settle();
    chk("R1 prio 0 silent", int'(irq_out), 0);
    wr(10'h003, 8'h20);
    wr(10'h102, 8'd6);
    rd(10'h102, rv); chk("R1 sw prio readback", int'(rv), 6);
    wr(10'h002, 8'h04); settle();
    chk("R8 sw irq", int'(irq_out), 1);
    chk("R8 sw vec", int'(vec_out), 2);
    ack_pin();
    rd(10'h001, rv); chk("R5 pin ignored", int'(rv), 0);
    settle();
    rd(10'h004, rv); chk("R5 vector read", int'(rv), 16'h8002);
    rd(10'h001, rv); chk("R5 read acks", int'(rv), 6);
    chk("R5 irq dropped", int'(irq_out), 0);
    wr(10'h003, 8'h04); rd(10'h002, rv); chk("R8 cleared", int'(rv), 0);
    wr(10'h005, 8'd0); rd(10'h001, rv); chk("R6 sw pop", int'(rv), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule